// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address, issued together with a privilege flag (user or kernel), into a physical address for a microcontroller bus. For each request it also reports which memory region the address hits, whether the access may be cached, and whether the access is illegal. The top half of the virtual space is reserved for kernel mode. Within that half, a cached window and an uncached window both map onto the same physical memory. The bottom half holds user windows into flash and RAM.

The boundary between kernel and user memory is set at run time through four partition registers. These are written and read through a small register port. Two further read-only entries report the total flash and RAM sizes. After reset the partitions give every byte to kernel mode. The result register also comes out of reset holding the boot fetch translation.

Top module: `atr_xlate`

## Requirements
- R1: While reset is asserted, and until the first accepted request, out_valid_o is 0. In that state out_paddr_o is 0x1FC00000, out_region_o is the boot code, out_cacheable_o is 0 and out_fault_o is 0. The region encoding is one-hot: bit0 program flash, bit1 data RAM, bit2 program RAM, bit3 peripheral registers, bit4 boot flash. The configuration reads after reset are: select 0, 1 and 2 return 0x20000; select 3 returns 0x80000; select 4 returns 0x80000; select 5 returns 0x20000.
- R2: A request sampled with in_valid_i high produces its result on the outputs after the next rising clock edge, and out_valid_o is 1 in that cycle. While in_valid_i is low, out_valid_o is 0 and the other outputs hold their previous values.
- R3: In kernel mode, any kernel address in 0x80000000..0xBFFFFFFF that hits a window gets the physical address vaddr AND 0x1FFFFFFF. Addresses in 0x80000000..0x9FFFFFFF are cacheable (1). Addresses in 0xA0000000..0xBFFFFFFF are uncached (0).
- R4: Take a kernel segment offset (vaddr AND 0x1FFFFFFF). An offset below the kernel RAM split (select 0) is data RAM. An offset from that split up to, but not including, the user data base (select 1) is program RAM.
- R5: Kernel program flash covers the offsets 0x1D000000 up to 0x1D000000 plus the user flash base (select 3), exclusive. It is reached at 0x9D000000 (cached) and at 0xBD000000 (uncached).
- R6: 0xBF800000..0xBF8FFFFF is the peripheral register region, and it is uncached. The cached alias 0x9F800000 faults.
- R7: Boot flash is the 12 KB starting at offset 0x1FC00000 (0xBFC00000 uncached, 0x9FC00000 cached). Offset 0x1FC03000 faults.
- R8: A user-mode request to any address with bit 31 set faults.
- R9: In either mode, user program flash spans 0x7D000000 plus select 3 up to 0x7D080000. Its physical address is vaddr minus 0x60000000, and it is cacheable.
- R10: In either mode, the user RAM window starts at 0x7F000000 and is 0x20000 minus select 1 bytes long. A hit maps to select 1 plus (vaddr minus 0x7F000000) and is cacheable. The region is data RAM when that physical address is below select 2, and program RAM otherwise.
- R11: An address that falls in no window faults. A faulting result has region 0, physical address 0 and cacheable 0. This includes kernel-mode addresses at or above 0xC0000000.
- R12: A write to select 0..3 is accepted only when bits 10:0 of the data are zero and the value does not exceed the memory size (0x20000 for selects 0..2, 0x80000 for select 3). Any other write leaves every readback unchanged. Selects 4 and 5 are read-only, and selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Request present this cycle |
| in_vaddr_i | input | 32 | Virtual address |
| in_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| cfg_wr_i | input | 1 | Partition register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_sel_i |
| out_valid_o | output | 1 | Result present |
| out_paddr_o | output | 32 | Physical address |
| out_region_o | output | 5 | One-hot region |
| out_cacheable_o | output | 1 | Cacheable attribute |
| out_fault_o | output | 1 | Access fault |

## Verification
Every translation result appears one clock edge after its request is sampled. A queue of expected results is filled when each request is driven. That queue is drained on the falling edge that follows the result's edge, whenever out_valid_o is high. Requests are issued back to back, so a design that adds or drops a stage returns mismatched results. Configuration readback is combinational and is sampled a moment after a falling edge in the same cycle. Partition writes are given a full cycle to land before any request that depends on them.

// File: rtl/atr_pkg.sv
package atr_pkg;

  localparam int unsigned REGION_W = 5;

  localparam logic [REGION_W-1:0] RGN_NONE  = 5'b00000;
  localparam logic [REGION_W-1:0] RGN_FLASH = 5'b00001;
  localparam logic [REGION_W-1:0] RGN_DRAM  = 5'b00010;
  localparam logic [REGION_W-1:0] RGN_PRAM  = 5'b00100;
  localparam logic [REGION_W-1:0] RGN_SFR   = 5'b01000;
  localparam logic [REGION_W-1:0] RGN_BOOT  = 5'b10000;

  // fixed physical placement of the memories
  localparam logic [31:0] FLASH_PBASE = 32'h1D00_0000;
  localparam logic [31:0] SFR_PBASE   = 32'h1F80_0000;
  localparam logic [31:0] BOOT_PBASE  = 32'h1FC0_0000;

  // user window virtual bases
  localparam logic [31:0] UFLASH_VBASE = 32'h7D00_0000;
  localparam logic [31:0] URAM_VBASE   = 32'h7F00_0000;
  localparam logic [31:0] UFLASH_SHIFT = 32'h6000_0000;

  typedef enum logic [2:0] {
    SEL_KRAM   = 3'd0,
    SEL_UDATA  = 3'd1,
    SEL_UPROG  = 3'd2,
    SEL_UFLASH = 3'd3,
    SEL_FSIZE  = 3'd4,
    SEL_RSIZE  = 3'd5
  } cfg_sel_e;

  typedef struct packed {
    logic [31:0] kram;
    logic [31:0] udata;
    logic [31:0] uprog;
    logic [31:0] uflash;
  } part_t;

  typedef struct packed {
    logic [31:0]         paddr;
    logic [REGION_W-1:0] region;
    logic                cacheable;
    logic                fault;
  } xlate_t;

endpackage

// File: rtl/atr_part_regs.sv
module atr_part_regs
  import atr_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 512 * 1024,
  parameter int unsigned RAM_BYTES   = 128 * 1024,
  parameter int unsigned ALIGN_LG    = 11
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [2:0]  sel_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output part_t       part_o
);

  localparam logic [31:0] FLASH_SZ = 32'(FLASH_BYTES);
  localparam logic [31:0] RAM_SZ   = 32'(RAM_BYTES);

  part_t       part_q, part_d;
  logic        load;
  logic [31:0] limit;
  logic        aligned;

  assign aligned = (wdata_i[ALIGN_LG-1:0] == '0);

  always_comb begin
    limit = (sel_i == SEL_UFLASH) ? FLASH_SZ : RAM_SZ;
    part_d = part_q;
    load   = 1'b0;
    if (wr_i && aligned && (wdata_i <= limit)) begin
      unique case (sel_i)
        SEL_KRAM:   begin part_d.kram   = wdata_i; load = 1'b1; end
        SEL_UDATA:  begin part_d.udata  = wdata_i; load = 1'b1; end
        SEL_UPROG:  begin part_d.uprog  = wdata_i; load = 1'b1; end
        SEL_UFLASH: begin part_d.uflash = wdata_i; load = 1'b1; end
        default:    load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q.kram   <= RAM_SZ;
      part_q.udata  <= RAM_SZ;
      part_q.uprog  <= RAM_SZ;
      part_q.uflash <= FLASH_SZ;
    end else if (load) begin
      part_q <= part_d;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_KRAM:   rdata_o = part_q.kram;
      SEL_UDATA:  rdata_o = part_q.udata;
      SEL_UPROG:  rdata_o = part_q.uprog;
      SEL_UFLASH: rdata_o = part_q.uflash;
      SEL_FSIZE:  rdata_o = FLASH_SZ;
      SEL_RSIZE:  rdata_o = RAM_SZ;
      default:    rdata_o = '0;
    endcase
  end

  assign part_o = part_q;

  // R12: misaligned data never lands
  a_r12_misaligned_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !aligned) |=> $stable(part_q));

  // R12: read-only and unused selects never change state
  a_r12_ro_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i > SEL_UFLASH) |=> $stable(part_q));

  // R12: accepted values stay within the memory size
  a_r12_within_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_q.kram <= RAM_SZ) && (part_q.uflash <= FLASH_SZ));

endmodule

// File: rtl/atr_decode.sv
module atr_decode
  import atr_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 512 * 1024,
  parameter int unsigned RAM_BYTES   = 128 * 1024,
  parameter int unsigned BOOT_BYTES  = 12 * 1024,
  parameter int unsigned SFR_BYTES   = 1024 * 1024
) (
  input  logic [31:0] vaddr_i,
  input  logic        user_i,
  input  part_t       part_i,
  output xlate_t      res_o
);

  localparam logic [31:0] FLASH_SZ  = 32'(FLASH_BYTES);
  localparam logic [31:0] RAM_SZ    = 32'(RAM_BYTES);
  localparam logic [31:0] SFR_END   = SFR_PBASE + 32'(SFR_BYTES);
  localparam logic [31:0] BOOT_END  = BOOT_PBASE + 32'(BOOT_BYTES);
  localparam logic [31:0] UFLASH_HI = UFLASH_VBASE + FLASH_SZ;

  logic [31:0] koff;
  logic        kseg, uncached_seg, useg;
  logic        k_flash, k_dram, k_pram, k_sfr, k_boot;
  logic [REGION_W-1:0] k_hits;
  logic [31:0] uram_off, uram_len, uram_phys;
  logic        u_flash, u_ram;

  assign koff         = {3'b000, vaddr_i[28:0]};
  assign kseg         = (vaddr_i[31:30] == 2'b10);
  assign uncached_seg = vaddr_i[29];
  assign useg         = !vaddr_i[31];

  // kernel windows, all in segment-offset space
  assign k_dram  = (koff < part_i.kram);
  assign k_pram  = (koff >= part_i.kram) && (koff < part_i.udata);
  assign k_flash = (koff >= FLASH_PBASE) && (koff < FLASH_PBASE + part_i.uflash);
  assign k_sfr   = uncached_seg && (koff >= SFR_PBASE) && (koff < SFR_END);
  assign k_boot  = (koff >= BOOT_PBASE) && (koff < BOOT_END);
  assign k_hits  = {k_boot, k_sfr, k_pram, k_dram, k_flash};

  // user windows
  assign u_flash   = useg && (vaddr_i >= UFLASH_VBASE + part_i.uflash) && (vaddr_i < UFLASH_HI);
  assign uram_off  = vaddr_i - URAM_VBASE;
  assign uram_len  = RAM_SZ - part_i.udata;
  assign uram_phys = part_i.udata + uram_off;
  assign u_ram     = useg && (vaddr_i >= URAM_VBASE) && (uram_off < uram_len);

  always_comb begin
    res_o = '{paddr: '0, region: RGN_NONE, cacheable: 1'b0, fault: 1'b1};
    if (kseg && !user_i) begin
      if (k_hits != RGN_NONE) begin
        res_o.paddr     = koff;
        res_o.region    = k_hits;
        res_o.cacheable = !uncached_seg;
        res_o.fault     = 1'b0;
      end
    end else if (useg) begin
      if (u_flash) begin
        res_o.paddr     = vaddr_i - UFLASH_SHIFT;
        res_o.region    = RGN_FLASH;
        res_o.cacheable = 1'b1;
        res_o.fault     = 1'b0;
      end else if (u_ram) begin
        res_o.paddr     = uram_phys;
        res_o.region    = (uram_phys < part_i.uprog) ? RGN_DRAM : RGN_PRAM;
        res_o.cacheable = 1'b1;
        res_o.fault     = 1'b0;
      end
    end
  end

endmodule

// File: rtl/atr_xlate.sv
module atr_xlate
  import atr_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 512 * 1024,
  parameter int unsigned RAM_BYTES   = 128 * 1024,
  parameter int unsigned BOOT_BYTES  = 12 * 1024,
  parameter int unsigned SFR_BYTES   = 1024 * 1024,
  parameter int unsigned ALIGN_LG    = 11,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [31:0]         in_vaddr_i,
  input  logic                in_user_i,
  input  logic                cfg_wr_i,
  input  logic [2:0]          cfg_sel_i,
  input  logic [31:0]         cfg_wdata_i,
  output logic [31:0]         cfg_rdata_o,
  output logic                out_valid_o,
  output logic [31:0]         out_paddr_o,
  output logic [REGION_W-1:0] out_region_o,
  output logic                out_cacheable_o,
  output logic                out_fault_o
);

  localparam xlate_t BOOT_RES = '{paddr: BOOT_PBASE, region: RGN_BOOT,
                                  cacheable: 1'b0, fault: 1'b0};

  // reset: asserted at once, released after RST_STAGES clock edges
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  part_t  part;
  xlate_t dec_res;
  xlate_t res_q, res_d;
  logic   valid_q, valid_d;

  atr_part_regs #(
    .FLASH_BYTES(FLASH_BYTES),
    .RAM_BYTES  (RAM_BYTES),
    .ALIGN_LG   (ALIGN_LG)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .wr_i   (cfg_wr_i),
    .sel_i  (cfg_sel_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .part_o (part)
  );

  atr_decode #(
    .FLASH_BYTES(FLASH_BYTES),
    .RAM_BYTES  (RAM_BYTES),
    .BOOT_BYTES (BOOT_BYTES),
    .SFR_BYTES  (SFR_BYTES)
  ) u_dec (
    .vaddr_i(in_vaddr_i),
    .user_i (in_user_i),
    .part_i (part),
    .res_o  (dec_res)
  );

  // next state
  always_comb begin
    valid_d = in_valid_i;
    res_d   = in_valid_i ? dec_res : res_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      res_q   <= BOOT_RES;
    end else begin
      valid_q <= valid_d;
      if (in_valid_i) res_q <= res_d;
    end
  end

  assign out_valid_o     = valid_q;
  assign out_paddr_o     = res_q.paddr;
  assign out_region_o    = res_q.region;
  assign out_cacheable_o = res_q.cacheable;
  assign out_fault_o     = res_q.fault;

  // R8: user mode never reaches kernel space
  a_r8_user_kernel_fault: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (in_valid_i && in_user_i && in_vaddr_i[31]) |=> (out_fault_o && out_region_o == RGN_NONE));

  // R11: a fault carries no region, address or cache attribute
  a_r11_fault_clean: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    out_fault_o |-> (out_region_o == RGN_NONE && out_paddr_o == '0 && !out_cacheable_o));

  // R1: a non-faulting result names exactly one region
  a_r1_region_onehot: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !out_fault_o |-> ($countones(out_region_o) == 1));

  // R3: the uncached kernel segment is never cacheable
  a_r3_uncached_seg: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (in_valid_i && !in_user_i && in_vaddr_i[31:29] == 3'b101) |=> !out_cacheable_o);

  // R3: kernel hits strip the top three address bits
  a_r3_kernel_paddr: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (in_valid_i && !in_user_i && in_vaddr_i[31:30] == 2'b10) |=>
      (out_fault_o || out_paddr_o == {3'b000, $past(in_vaddr_i[28:0])}));

  // R2: idle cycles hold the result and drop valid
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !in_valid_i |=> (!out_valid_o && $stable(out_paddr_o) && $stable(out_region_o)));

endmodule

// File: tb/sim_atr_xlate.sv
module sim_atr_xlate;

  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] RF = 5'b00001;
  localparam logic [4:0] RD = 5'b00010;
  localparam logic [4:0] RP = 5'b00100;
  localparam logic [4:0] RS = 5'b01000;
  localparam logic [4:0] RB = 5'b10000;
  localparam logic [4:0] RN = 5'b00000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_user;
  logic [31:0] in_vaddr;
  logic        cfg_wr;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        out_valid, out_cacheable, out_fault;
  logic [31:0] out_paddr;
  logic [4:0]  out_region;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] pa;
    logic [4:0]  rg;
    logic        ca;
    logic        fl;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  atr_xlate u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .in_valid_i     (in_valid),
    .in_vaddr_i     (in_vaddr),
    .in_user_i      (in_user),
    .cfg_wr_i       (cfg_wr),
    .cfg_sel_i      (cfg_sel),
    .cfg_wdata_i    (cfg_wdata),
    .cfg_rdata_o    (cfg_rdata),
    .out_valid_o    (out_valid),
    .out_paddr_o    (out_paddr),
    .out_region_o   (out_region),
    .out_cacheable_o(out_cacheable),
    .out_fault_o    (out_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected item per valid result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R2 unexpected result: actual %h expected none", out_paddr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " paddr"},  64'(out_paddr),     64'(e.pa));
        chk({e.tag, " region"}, 64'(out_region),    64'(e.rg));
        chk({e.tag, " cache"},  64'(out_cacheable), 64'(e.ca));
        chk({e.tag, " fault"},  64'(out_fault),     64'(e.fl));
      end
    end
  end

  task automatic xl(input logic [31:0] va, input logic usr, input logic [31:0] pa,
                    input logic [4:0] rg, input logic ca, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_vaddr = va;
    in_user  = usr;
    e.pa = pa; e.rg = rg; e.ca = ca; e.fl = 1'b0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic xf(input logic [31:0] va, input logic usr, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_vaddr = va;
    in_user  = usr;
    e.pa = '0; e.rg = RN; e.ca = 1'b0; e.fl = 1'b1; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    in_vaddr = 32'hBFC0_0000;
    in_user  = ~in_user;
    repeat (2) @(negedge clk);
    chk("R2 queue empty", 64'(sb.size()), 64'd0);
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_vaddr = '0; in_user = 1'b0;
    cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid",  64'(out_valid),     64'd0);
    chk("R1 paddr",  64'(out_paddr),     64'h1FC0_0000);
    chk("R1 region", 64'(out_region),    64'(RB));
    chk("R1 cache",  64'(out_cacheable), 64'd0);
    chk("R1 fault",  64'(out_fault),     64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after release", 64'(out_valid), 64'd0);
    chk("R1 paddr after release", 64'(out_paddr), 64'h1FC0_0000);
    cfg_read(3'd0, 32'h2_0000, "R1 sel0");
    cfg_read(3'd1, 32'h2_0000, "R1 sel1");
    cfg_read(3'd2, 32'h2_0000, "R1 sel2");
    cfg_read(3'd3, 32'h8_0000, "R1 sel3");
    cfg_read(3'd4, 32'h8_0000, "R1 sel4");
    cfg_read(3'd5, 32'h2_0000, "R1 sel5");
    cfg_read(3'd6, 32'h0,      "R12 sel6");

    // default map, all memory to kernel
    xl(32'h8000_0100, 1'b0, 32'h0000_0100, RD, 1'b1, "R3 k0 dram");
    xl(32'hA000_0100, 1'b0, 32'h0000_0100, RD, 1'b0, "R3 k1 dram");
    xl(32'h8001_FFFC, 1'b0, 32'h0001_FFFC, RD, 1'b1, "R4 top dram");
    xf(32'h8002_0000, 1'b0, "R4 past ram");
    xl(32'h9D07_FFFC, 1'b0, 32'h1D07_FFFC, RF, 1'b1, "R5 k0 flash");
    xl(32'hBD00_0000, 1'b0, 32'h1D00_0000, RF, 1'b0, "R5 k1 flash");
    xf(32'hBD08_0000, 1'b0, "R5 past flash");
    xl(32'hBF80_0000, 1'b0, 32'h1F80_0000, RS, 1'b0, "R6 sfr lo");
    xl(32'hBF8F_FFFC, 1'b0, 32'h1F8F_FFFC, RS, 1'b0, "R6 sfr hi");
    xf(32'h9F80_0000, 1'b0, "R6 cached sfr");
    xl(32'hBFC0_0000, 1'b0, 32'h1FC0_0000, RB, 1'b0, "R7 boot");
    xl(32'h9FC0_2FFC, 1'b0, 32'h1FC0_2FFC, RB, 1'b1, "R7 boot cached top");
    xf(32'hBFC0_3000, 1'b0, "R7 past boot");
    xf(32'h8000_0100, 1'b1, "R8 user k0");
    xf(32'hBFC0_0000, 1'b1, "R8 user boot");
    xf(32'h7D00_0000, 1'b1, "R9 no user flash");
    xf(32'h7F00_0000, 1'b1, "R10 no user ram");
    xf(32'hC000_0000, 1'b0, "R11 kseg above");
    xf(32'h0000_1000, 1'b0, "R11 low user");
    drain();

    // partition writes
    cfg_write(3'd0, 32'h0000_8000);
    cfg_write(3'd1, 32'h0001_0000);
    cfg_write(3'd2, 32'h0001_8000);
    cfg_write(3'd3, 32'h0006_0000);
    cfg_read(3'd0, 32'h0000_8000, "R12 sel0 accepted");
    cfg_read(3'd1, 32'h0001_0000, "R12 sel1 accepted");
    cfg_read(3'd2, 32'h0001_8000, "R12 sel2 accepted");
    cfg_read(3'd3, 32'h0006_0000, "R12 sel3 accepted");
    cfg_write(3'd0, 32'h0000_8400);
    cfg_read(3'd0, 32'h0000_8000, "R12 misaligned ignored");
    cfg_write(3'd3, 32'h0008_0800);
    cfg_read(3'd3, 32'h0006_0000, "R12 flash oversize ignored");
    cfg_write(3'd1, 32'h0002_0800);
    cfg_read(3'd1, 32'h0001_0000, "R12 ram oversize ignored");
    cfg_write(3'd4, 32'h0000_1000);
    cfg_read(3'd4, 32'h0008_0000, "R12 size read-only");

    // split map
    xl(32'h8000_7FFC, 1'b0, 32'h0000_7FFC, RD, 1'b1, "R4 split dram");
    xl(32'hA000_8000, 1'b0, 32'h0000_8000, RP, 1'b0, "R4 split pram");
    xl(32'h8000_FFFC, 1'b0, 32'h0000_FFFC, RP, 1'b1, "R4 pram top");
    xf(32'h8001_0000, 1'b0, "R4 user ram hidden");
    xl(32'h9D05_FFFC, 1'b0, 32'h1D05_FFFC, RF, 1'b1, "R5 split flash top");
    xf(32'h9D06_0000, 1'b0, "R5 user flash hidden");
    xl(32'h7D06_0000, 1'b1, 32'h1D06_0000, RF, 1'b1, "R9 user flash lo");
    xl(32'h7D07_FFFC, 1'b1, 32'h1D07_FFFC, RF, 1'b1, "R9 user flash hi");
    xf(32'h7D05_FFFC, 1'b1, "R9 below user flash");
    xf(32'h7D08_0000, 1'b1, "R9 above user flash");
    xl(32'h7D06_0000, 1'b0, 32'h1D06_0000, RF, 1'b1, "R9 kernel reach");
    xl(32'h7F00_0000, 1'b1, 32'h0001_0000, RD, 1'b1, "R10 uram base");
    xl(32'h7F00_7FFC, 1'b1, 32'h0001_7FFC, RD, 1'b1, "R10 udata top");
    xl(32'h7F00_8000, 1'b1, 32'h0001_8000, RP, 1'b1, "R10 uprog base");
    xf(32'h7F01_0000, 1'b1, "R10 past uram");
    xf(32'h0000_0000, 1'b1, "R11 user zero");
    xl(32'h7F00_FFFC, 1'b0, 32'h0001_FFFC, RP, 1'b1, "R10 uprog top");
    drain();
    // R2: outputs held from the last request while idle
    chk("R2 idle valid",  64'(out_valid),  64'd0);
    chk("R2 idle paddr",  64'(out_paddr),  64'h0001_FFFC);
    chk("R2 idle region", 64'(out_region), 64'(RP));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule